// File: doc/BRIEF.md
# Dual-Port Memory with Cross-Port Doorbell Flags

This block is a true dual-port word memory shared by two agents, called the left port and the right port. Each port has its own active-low chip enable, output enable and write enable, its own word address and its own write and read data buses. Either port may read or write any word in any cycle. Everything is clocked by one clock: inputs are sampled at the rising edge, writes land at that edge and read data is registered.

The two highest word addresses double as mailboxes. A write from one port into its partner's mailbox raises a doorbell flag toward that partner, which sees it as an active-low interrupt output. The partner drops the flag by accessing its own mailbox with chip enable and output enable both active, which is also how it fetches the message. The mailbox words stay ordinary storage. A configuration input turns the doorbell function off, and the two top words are then plain memory.

The address width is a parameter. The default build has 11 address bits, so the left mailbox is at 0x7FE and the right mailbox is at 0x7FF. A build with 14 address bits gives 16K words with the mailboxes at 0x3FFE and 0x3FFF.

Top module: `dpmb_top`

## Requirements
- R1: A write on a port (chip enable low, write enable low) stores its data at the rising edge. A read (chip enable low, output enable low, write enable high) presents the stored word on that port's read bus after the same edge. A read of a word that the other port writes in the same cycle returns the old contents. The two ports work independently.
- R2: If both ports write the same address in the same cycle, the left port's data is kept.
- R3: With the doorbell enabled, a right-port write to the left mailbox (top address minus one, 0x7FE by default) drives `l_irq_n` low from the following cycle.
- R4: With the doorbell enabled, a left-port access to 0x7FE with chip enable and output enable low clears the left flag, so `l_irq_n` returns high in the following cycle. The write enable level does not matter for this clear.
- R5: With the doorbell enabled, a left-port write to the right mailbox (top address, 0x7FF by default) drives `r_irq_n` low from the following cycle.
- R6: With the doorbell enabled, a right-port access to 0x7FF with chip enable and output enable low clears the right flag in the same way. The write enable level does not matter.
- R7: If a setting write and a clearing access hit the same mailbox in the same cycle, the flag ends up set.
- R8: The mailbox words hold the written message and read back like any other word.
- R9: While `mbox_en` is low, neither flag changes, and the mailbox words behave as plain memory.
- R10: A port whose chip enable is high writes nothing, leaves its read bus unchanged, and neither sets nor clears a flag.
- R11: In reset, both interrupt outputs are high and both read buses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mbox_en | input | 1 | High enables the doorbell flags |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_we_n | input | 1 | Left write enable, active low |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left registered read data |
| l_irq_n | output | 1 | Left doorbell interrupt, active low |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_we_n | input | 1 | Right write enable, active low |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right registered read data |
| r_irq_n | output | 1 | Right doorbell interrupt, active low |

## Verification
All results are due one cycle after the edge that samples the stimulus. Read data, flag sets and flag clears appear on the ports just after that edge, and a write shows up through a read issued in any later cycle. The bench holds each input vector from one falling edge to the next. It advances a behavioural model at the rising edge and compares both read buses and both interrupts at the following falling edge, so every comparison falls exactly one edge after its stimulus. Directed phases cover each corner case. A long random phase over a small address set, including both mailboxes, follows them.

// File: rtl/dpmb_pkg.sv
package dpmb_pkg;

    // Decoded intent of one port in the current cycle
    typedef struct packed {
        logic wr;        // write of a word
        logic rd;        // read into the registered output
        logic own_hit;   // enabled, output-enabled access of this port's own mailbox
        logic peer_hit;  // write into the partner's mailbox
    } port_req_t;

    // One bit per side
    typedef struct packed {
        logic left;
        logic right;
    } side_pair_t;

    typedef enum logic [0:0] {
        SIDE_L = 1'b0,
        SIDE_R = 1'b1
    } side_e;

endpackage

// File: rtl/dpmb_port_dec.sv
module dpmb_port_dec
    import dpmb_pkg::*;
#(
    parameter int                ADDR_W   = 11,
    parameter logic [ADDR_W-1:0] OWN_BOX  = '1,
    parameter logic [ADDR_W-1:0] PEER_BOX = '0
) (
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output port_req_t         req
);

    logic sel;
    logic own_match;
    logic peer_match;

    always_comb begin
        sel        = ~ce_n;
        own_match  = (addr == OWN_BOX);
        peer_match = (addr == PEER_BOX);

        req          = '0;
        req.wr       = sel & ~we_n;
        req.rd       = sel & ~oe_n & we_n;
        // The clear ignores the write enable level
        req.own_hit  = sel & ~oe_n & own_match;
        req.peer_hit = sel & ~we_n & peer_match;
    end

endmodule

// File: rtl/dpmb_storage.sv
module dpmb_storage #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16,
    parameter int PORTS  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [PORTS-1:0]              wr,
    input  logic [PORTS-1:0]              rd,
    input  logic [PORTS-1:0][ADDR_W-1:0]  addr,
    input  logic [PORTS-1:0][DATA_W-1:0]  wdata,
    output logic [PORTS-1:0][DATA_W-1:0]  rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    logic [PORTS-1:0][DATA_W-1:0] rdata_d, rdata_q;
    logic [PORTS-1:0]             wr_eff;

    // A lower-numbered port wins a same-address write collision
    always_comb begin
        for (int p = 0; p < PORTS; p++) begin
            wr_eff[p] = wr[p];
            for (int q = 0; q < p; q++) begin
                if (wr[q] && addr[q] == addr[p]) wr_eff[p] = 1'b0;
            end
        end
    end

    // Read-first: read data comes from the contents before this edge's writes
    always_comb begin
        rdata_d = rdata_q;
        for (int p = 0; p < PORTS; p++) begin
            if (rd[p]) rdata_d[p] = mem[addr[p]];
        end
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < PORTS; p++) begin
            if (wr_eff[p]) mem[addr[p]] <= wdata[p];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    // R10: a port that does not read keeps its output
    generate
        for (genvar g = 0; g < PORTS; g++) begin : g_hold_chk
            p_rd_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
                !rd[g] |=> $stable(rdata[g]));
        end
    endgenerate

endmodule

// File: rtl/dpmb_flags.sv
module dpmb_flags
    import dpmb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  side_pair_t set_i,
    input  side_pair_t clr_i,
    output side_pair_t flag_o
);

    typedef struct packed {
        side_pair_t flag;
    } state_t;

    state_t st_d, st_q;

    function automatic logic next_flag(input logic cur, input logic en,
                                       input logic set, input logic clr);
        logic nxt;
        nxt = cur;
        if (en) begin
            if (set)      nxt = 1'b1;  // set outranks clear
            else if (clr) nxt = 1'b0;
        end
        return nxt;
    endfunction

    always_comb begin
        st_d            = st_q;
        st_d.flag.left  = next_flag(st_q.flag.left,  enable, set_i.left,  clr_i.left);
        st_d.flag.right = next_flag(st_q.flag.right, enable, set_i.right, clr_i.right);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    // R7: a set and a clear in the same cycle leave the flag set
    p_set_wins_l_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (enable && set_i.left && clr_i.left) |=> flag_o.left);
    p_set_wins_r_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (enable && set_i.right && clr_i.right) |=> flag_o.right);

endmodule

// File: rtl/dpmb_top.sv
module dpmb_top
    import dpmb_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mbox_en,
    input  logic              l_ce_n,
    input  logic              l_oe_n,
    input  logic              l_we_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_irq_n,
    input  logic              r_ce_n,
    input  logic              r_oe_n,
    input  logic              r_we_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_irq_n
);

    localparam int                DEPTH  = 1 << ADDR_W;
    localparam int                NPORT  = 2;
    localparam logic [ADDR_W-1:0] BOX_L  = ADDR_W'(DEPTH - 2);
    localparam logic [ADDR_W-1:0] BOX_R  = ADDR_W'(DEPTH - 1);

    logic [NPORT-1:0]             ce_n_a, oe_n_a, we_n_a;
    logic [NPORT-1:0][ADDR_W-1:0] addr_a;
    logic [NPORT-1:0][DATA_W-1:0] wdata_a, rdata_a;
    port_req_t                    req [NPORT];
    logic [NPORT-1:0]             wr_a, rd_a;
    side_pair_t                   set_s, clr_s, flag_s;

    assign ce_n_a[SIDE_L]  = l_ce_n;   assign ce_n_a[SIDE_R]  = r_ce_n;
    assign oe_n_a[SIDE_L]  = l_oe_n;   assign oe_n_a[SIDE_R]  = r_oe_n;
    assign we_n_a[SIDE_L]  = l_we_n;   assign we_n_a[SIDE_R]  = r_we_n;
    assign addr_a[SIDE_L]  = l_addr;   assign addr_a[SIDE_R]  = r_addr;
    assign wdata_a[SIDE_L] = l_wdata;  assign wdata_a[SIDE_R] = r_wdata;

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            localparam logic [ADDR_W-1:0] OWN  = (p == 0) ? BOX_L : BOX_R;
            localparam logic [ADDR_W-1:0] PEER = (p == 0) ? BOX_R : BOX_L;

            dpmb_port_dec #(
                .ADDR_W   (ADDR_W),
                .OWN_BOX  (OWN),
                .PEER_BOX (PEER)
            ) i_dec (
                .ce_n (ce_n_a[p]),
                .oe_n (oe_n_a[p]),
                .we_n (we_n_a[p]),
                .addr (addr_a[p]),
                .req  (req[p])
            );

            assign wr_a[p] = req[p].wr;
            assign rd_a[p] = req[p].rd;
        end
    endgenerate

    // A write into a mailbox rings the opposite side; the owner clears its own
    assign set_s.left  = req[SIDE_R].peer_hit;
    assign set_s.right = req[SIDE_L].peer_hit;
    assign clr_s.left  = req[SIDE_L].own_hit;
    assign clr_s.right = req[SIDE_R].own_hit;

    dpmb_storage #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PORTS  (NPORT)
    ) i_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_a),
        .rd    (rd_a),
        .addr  (addr_a),
        .wdata (wdata_a),
        .rdata (rdata_a)
    );

    dpmb_flags i_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (mbox_en),
        .set_i  (set_s),
        .clr_i  (clr_s),
        .flag_o (flag_s)
    );

    assign l_rdata = rdata_a[SIDE_L];
    assign r_rdata = rdata_a[SIDE_R];
    assign l_irq_n = ~flag_s.left;
    assign r_irq_n = ~flag_s.right;

    // R3: a right write to the left mailbox rings the left side
    p_ring_left_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_en && !r_ce_n && !r_we_n && r_addr == BOX_L) |=> !l_irq_n);

    // R4: the left side's own access silences it unless a ring arrives at once
    p_clear_left_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_en && !l_ce_n && !l_oe_n && l_addr == BOX_L &&
         !(!r_ce_n && !r_we_n && r_addr == BOX_L)) |=> l_irq_n);

    // R5: a left write to the right mailbox rings the right side
    p_ring_right_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_en && !l_ce_n && !l_we_n && l_addr == BOX_R) |=> !r_irq_n);

    // R6: the right side's own access silences it unless a ring arrives at once
    p_clear_right_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_en && !r_ce_n && !r_oe_n && r_addr == BOX_R &&
         !(!l_ce_n && !l_we_n && l_addr == BOX_R)) |=> !r_irq_n == 1'b0);

    // R9: with the doorbell off the interrupt lines hold
    p_off_hold_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        !mbox_en |=> ($stable(l_irq_n) && $stable(r_irq_n)));

    // R10: with both ports deselected nothing visible moves
    p_idle_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        (l_ce_n && r_ce_n) |=> ($stable(l_irq_n) && $stable(r_irq_n) &&
                                $stable(l_rdata) && $stable(r_rdata)));

endmodule

// File: tb/test_dpmb_top.sv
module test_dpmb_top;

    localparam int AW    = 11;
    localparam int DW    = 16;
    localparam int TOP   = (1 << AW) - 1;
    localparam int BOX_L = TOP - 1;
    localparam int BOX_R = TOP;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mbox_en = 1'b1;
    logic          l_ce_n = 1'b1, l_oe_n = 1'b1, l_we_n = 1'b1;
    logic          r_ce_n = 1'b1, r_oe_n = 1'b1, r_we_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic          l_irq_n, r_irq_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Behavioural reference state
    logic [DW-1:0] m_mem [int];
    logic [DW-1:0] m_lrd = '0, m_rrd = '0;
    bit            m_lknown = 1'b1, m_rknown = 1'b1;
    bit            m_lflag = 1'b0, m_rflag = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    dpmb_top #(.ADDR_W(AW), .DATA_W(DW)) i_dpmb_top (
        .clk(clk), .rst_n(rst_n), .mbox_en(mbox_en),
        .l_ce_n(l_ce_n), .l_oe_n(l_oe_n), .l_we_n(l_we_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
        .r_ce_n(r_ce_n), .r_oe_n(r_oe_n), .r_we_n(r_we_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
    );

    task automatic check(input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic drive_l(input bit ce, input bit oe, input bit we,
                           input int a, input logic [DW-1:0] d);
        l_ce_n = ce; l_oe_n = oe; l_we_n = we; l_addr = AW'(a); l_wdata = d;
    endtask

    task automatic drive_r(input bit ce, input bit oe, input bit we,
                           input int a, input logic [DW-1:0] d);
        r_ce_n = ce; r_oe_n = oe; r_we_n = we; r_addr = AW'(a); r_wdata = d;
    endtask

    task automatic idle();
        drive_l(1, 1, 1, 0, '0);
        drive_r(1, 1, 1, 0, '0);
    endtask

    // One clock: advance the model from the held inputs, then compare
    task automatic cyc(input string tag);
        bit lwr, lrd, rwr, rrd, set_l, clr_l, set_r, clr_r;
        int la, ra;
        la  = int'(l_addr);
        ra  = int'(r_addr);
        lwr = !l_ce_n && !l_we_n;
        rwr = !r_ce_n && !r_we_n;
        lrd = !l_ce_n && !l_oe_n && l_we_n;
        rrd = !r_ce_n && !r_oe_n && r_we_n;
        set_l = mbox_en && rwr && ra == BOX_L;
        clr_l = mbox_en && !l_ce_n && !l_oe_n && la == BOX_L;
        set_r = mbox_en && lwr && la == BOX_R;
        clr_r = mbox_en && !r_ce_n && !r_oe_n && ra == BOX_R;
        @(posedge clk);
        if (lrd) begin
            m_lknown = m_mem.exists(la);
            m_lrd    = m_lknown ? m_mem[la] : '0;
        end
        if (rrd) begin
            m_rknown = m_mem.exists(ra);
            m_rrd    = m_rknown ? m_mem[ra] : '0;
        end
        if (set_l) m_lflag = 1'b1; else if (clr_l) m_lflag = 1'b0;
        if (set_r) m_rflag = 1'b1; else if (clr_r) m_rflag = 1'b0;
        if (rwr && !(lwr && la == ra)) m_mem[ra] = r_wdata;
        if (lwr) m_mem[la] = l_wdata;
        @(negedge clk);
        if (m_lknown) check(tag, "l_rdata", l_rdata, m_lrd);
        if (m_rknown) check(tag, "r_rdata", r_rdata, m_rrd);
        check(tag, "l_irq_n", DW'(l_irq_n), DW'(!m_lflag));
        check(tag, "r_irq_n", DW'(r_irq_n), DW'(!m_rflag));
    endtask

    initial begin : watchdog
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset values
        check("R11", "l_irq_n", DW'(l_irq_n), DW'(1));
        check("R11", "r_irq_n", DW'(r_irq_n), DW'(1));
        check("R11", "l_rdata", l_rdata, '0);
        check("R11", "r_rdata", r_rdata, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: fill a small window from both ports, then read back crosswise
        for (int a = 0; a < 16; a += 2) begin
            drive_l(0, 1, 0, a, DW'(16'h1000 + a));
            drive_r(0, 1, 0, a + 1, DW'(16'h2000 + a));
            cyc("R1");
        end
        for (int a = 0; a < 16; a++) begin
            drive_l(0, 0, 1, a, '0);
            drive_r(0, 0, 1, 15 - a, '0);
            cyc("R1");
        end
        // R1: read old data while the other port overwrites
        drive_l(0, 0, 1, 3, '0);
        drive_r(0, 1, 0, 3, 16'hBEEF);
        cyc("R1");
        drive_r(0, 0, 1, 3, '0); drive_l(1, 1, 1, 0, '0);
        cyc("R1");

        // R2: colliding writes keep the left value
        drive_l(0, 1, 0, 5, 16'hAAAA);
        drive_r(0, 1, 0, 5, 16'h5555);
        cyc("R2");
        drive_l(1, 1, 1, 0, '0); drive_r(0, 0, 1, 5, '0);
        cyc("R2");

        // R3, R8: right rings left with a message
        idle(); drive_r(0, 1, 0, BOX_L, 16'h00A5);
        cyc("R3");
        idle(); cyc("R3");
        // R4, R8: left reads its box, sees the message, drops its flag
        drive_l(0, 0, 1, BOX_L, '0);
        cyc("R4");
        idle(); cyc("R8");
        // R4: clear with write enable active as well
        drive_r(0, 1, 0, BOX_L, 16'h0011); cyc("R3");
        idle(); drive_l(0, 0, 0, BOX_L, 16'h0022); cyc("R4");
        idle(); drive_r(0, 0, 1, BOX_L, '0); cyc("R8");

        // R5, R6: left rings right, right clears with either write enable level
        idle(); drive_l(0, 1, 0, BOX_R, 16'h005A); cyc("R5");
        idle(); drive_r(0, 0, 1, BOX_R, '0); cyc("R6");
        idle(); drive_l(0, 1, 0, BOX_R, 16'h0077); cyc("R5");
        idle(); drive_r(0, 0, 0, BOX_R, 16'h0078); cyc("R6");
        idle(); drive_l(0, 0, 1, BOX_R, '0); cyc("R8");

        // R7: ring and clear together leave the flag set, on both sides
        idle(); drive_r(0, 1, 0, BOX_L, 16'h0101); drive_l(0, 0, 1, BOX_L, '0); cyc("R7");
        idle(); drive_l(0, 1, 0, BOX_R, 16'h0202); drive_r(0, 0, 1, BOX_R, '0); cyc("R7");
        idle(); cyc("R7");
        drive_l(0, 0, 1, BOX_L, '0); drive_r(0, 0, 1, BOX_R, '0); cyc("R7");

        // R9: doorbell off, mailbox writes and reads are plain memory
        idle(); mbox_en = 1'b0;
        drive_r(0, 1, 0, BOX_L, 16'h0303); drive_l(0, 1, 0, BOX_R, 16'h0404); cyc("R9");
        idle(); drive_l(0, 0, 1, BOX_L, '0); drive_r(0, 0, 1, BOX_R, '0); cyc("R9");
        idle(); mbox_en = 1'b1;
        drive_r(0, 1, 0, BOX_L, 16'h0505); cyc("R9");
        idle(); mbox_en = 1'b0; drive_l(0, 0, 1, BOX_L, '0); cyc("R9");
        idle(); mbox_en = 1'b1; cyc("R9");

        // R10: deselected ports with other strobes active do nothing
        drive_l(1, 0, 0, BOX_R, 16'hDEAD); drive_r(1, 0, 0, BOX_R, 16'hDEAD); cyc("R10");
        drive_l(1, 0, 1, BOX_L, '0); drive_r(1, 0, 0, BOX_L, 16'hDEAD); cyc("R10");
        idle(); drive_l(0, 0, 1, BOX_R, '0); drive_r(0, 0, 1, BOX_L, '0); cyc("R10");
        idle(); drive_l(0, 0, 1, BOX_L, '0); cyc("R10");

        // R1: random traffic over the window and both mailboxes
        for (int n = 0; n < 3000; n++) begin
            int sel_l, sel_r;
            sel_l = $urandom_range(0, 17);
            sel_r = $urandom_range(0, 17);
            mbox_en = ($urandom_range(0, 7) != 0);
            drive_l($urandom_range(0, 3) == 0, $urandom_range(0, 1), $urandom_range(0, 1),
                    sel_l < 16 ? sel_l : TOP - (sel_l - 16), DW'($urandom));
            drive_r($urandom_range(0, 3) == 0, $urandom_range(0, 1), $urandom_range(0, 1),
                    sel_r < 16 ? sel_r : TOP - (sel_r - 16), DW'($urandom));
            cyc("R1");
        end

        done = 1'b1;
        finish_run();
    end

endmodule